// File: doc/BRIEF.md
# Fast-Lock Charge-Boost Pulse Controller

This block controls a tri-stateable boost output. During PLL acquisition, that output gives the loop filter an extra charge so the loop locks faster. A 5-bit level code arrives from the control word. Two events arm a boost window: a rising edge on the operate input, or a falling edge on the latch-enable input, which marks a committed data write. When a window is armed, the block latches the code and drives it on a level bus with an active-high drive enable. It keeps driving until the reference-comparison strobe has fired twice. It then releases the output, which means high impedance.

A code of zero turns the function off. A trigger that carries a zero code opens no window. If a window is already running, such a trigger closes it. A trigger that arrives while a window is running starts the count again with the newly latched code. A strobe that falls in the same cycle as a trigger does not count toward the window. Conversion of the code to an analog voltage is outside this block.

Top module: `fastlock_boost_ctrl`

## Requirements
- R1: While reset is applied, and until the first trigger after it, drive_en_o is 0 and boost_level_o is 0.
- R2: A rising edge on opr_i with a nonzero code sets drive_en_o in the next cycle, and boost_level_o then carries the code sampled on the edge cycle.
- R3: A falling edge on le_i with a nonzero code starts a window in the same way as R2.
- R4: A window lasts until the second fr_i strobe after the trigger cycle. drive_en_o falls in the cycle after that strobe's cycle.
- R5: An fr_i strobe in the same cycle as a trigger is not counted toward the window.
- R6: A trigger with code 0 keeps drive_en_o low, and it ends any window in progress.
- R7: A trigger during an active window restarts the two-strobe count and loads the new code.
- R8: When drive_en_o is 0, boost_level_o is all zeros, which models high impedance.
- R9: A falling edge on opr_i and a rising edge on le_i start nothing and leave an active window unchanged.
- R10: Changes on code_i outside trigger cycles leave boost_level_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_i | input | 5 | Boost level code from the control word |
| fr_i | input | 1 | Reference-comparison strobe, one cycle per event |
| opr_i | input | 1 | Operate input, synchronous level |
| le_i | input | 1 | Latch-enable input, synchronous level |
| boost_level_o | output | 5 | Driven boost level, zero when released |
| drive_en_o | output | 1 | High while the boost output is driven |

## Verification
A trigger and a window-closing fr_i strobe can land in the same clock cycle. A trigger can also coincide with the first strobe of a fresh window. The bench forces both cases with directed sequences: a strobe on the trigger cycle, and a retrigger on the second strobe. The random phase mixes them further with independent edge and strobe probabilities. In every case the outcome is judged against a bench model. In that model the trigger always wins, and the coincident strobe is dropped, so the window runs a full two further strobes with the new code.

// File: rtl/fastlock_pkg.sv
package fastlock_pkg;
  localparam int unsigned LVL_W_DEF = 5;
  localparam int unsigned WIN_DEF   = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_OPR  = 2'b01,
    SRC_LE   = 2'b10,
    SRC_BOTH = 2'b11
  } trig_src_e;
endpackage

// File: rtl/fl_rst_sync.sv
module fl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/fl_trig_detect.sv
module fl_trig_detect
  import fastlock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      opr_i,
  input  logic      le_i,
  output logic      trig_o,
  output trig_src_e src_o
);
  logic opr_q, le_q;
  logic opr_d, le_d;

  // Reset values are chosen so that a static input level never looks like an edge.
  always_comb begin
    opr_d = opr_i;
    le_d  = le_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opr_q <= 1'b1;
      le_q  <= 1'b0;
    end else begin
      opr_q <= opr_d;
      le_q  <= le_d;
    end
  end

  always_comb begin
    src_o  = trig_src_e'({le_q & ~le_i, opr_i & ~opr_q});
    trig_o = (src_o != SRC_NONE);
  end
endmodule

// File: rtl/fl_window_ctr.sv
module fl_window_ctr #(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned WIN   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             fr_i,
  input  logic [LVL_W-1:0] code_i,
  output logic             active_o,
  output logic [LVL_W-1:0] lvl_o
);
  localparam int unsigned CNT_W = $clog2(WIN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             lvl_en;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    lvl_en = 1'b0;
    if (trig_i) begin
      // trigger wins over a coincident strobe, which is not counted
      lvl_en = 1'b1;
      lvl_d  = code_i;
      cnt_d  = CNT_LOAD;
      act_d  = |code_i;
    end else if (act_q && fr_i) begin
      cnt_d = cnt_q - CNT_LAST;
      if (cnt_q == CNT_LAST) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  assign active_o = act_q;
  assign lvl_o    = lvl_q;
endmodule

// File: rtl/fl_drive_stage.sv
module fl_drive_stage #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             active_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0] level_o,
  output logic             en_o
);
  always_comb begin
    en_o    = active_i;
    level_o = active_i ? lvl_i : '0;
  end
endmodule

// File: rtl/fastlock_boost_ctrl.sv
module fastlock_boost_ctrl
  import fastlock_pkg::*;
#(
  parameter int unsigned LVL_W = LVL_W_DEF,
  parameter int unsigned WIN   = WIN_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] code_i,
  input  logic             fr_i,
  input  logic             opr_i,
  input  logic             le_i,
  output logic [LVL_W-1:0] boost_level_o,
  output logic             drive_en_o
);
  logic             rst_core_n;
  logic             trig_w;
  trig_src_e        src_w;
  logic             active_w;
  logic [LVL_W-1:0] lvl_w;

  fl_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_core_n)
  );

  fl_trig_detect u_trig (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .opr_i  (opr_i),
    .le_i   (le_i),
    .trig_o (trig_w),
    .src_o  (src_w)
  );

  fl_window_ctr #(.LVL_W(LVL_W), .WIN(WIN)) u_win (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .trig_i   (trig_w),
    .fr_i     (fr_i),
    .code_i   (code_i),
    .active_o (active_w),
    .lvl_o    (lvl_w)
  );

  fl_drive_stage #(.LVL_W(LVL_W)) u_drv (
    .active_i (active_w),
    .lvl_i    (lvl_w),
    .level_o  (boost_level_o),
    .en_o     (drive_en_o)
  );

  logic unused_src;
  assign unused_src = ^src_w;
endmodule

// File: rtl/fastlock_boost_chk.sv
module fastlock_boost_chk #(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned WIN   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             fr_i,
  input logic [LVL_W-1:0] code_i,
  input logic [LVL_W-1:0] level_o,
  input logic             en
);
  localparam int unsigned CW = $clog2(WIN + 1);
  logic [CW-1:0] seen_q;

  // strobes counted since the last trigger while driving
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   seen_q <= '0;
    else if (trig)                                seen_q <= '0;
    else if (en && fr_i && (seen_q < CW'(WIN)))   seen_q <= seen_q + CW'(1);
  end

  assert_released_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (level_o == '0));

  assert_start_from_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> $past(trig));

  assert_load_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && (code_i != '0)) |=> (en && (level_o == $past(code_i))));

  assert_zero_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && (code_i == '0)) |=> !en);

  assert_window_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (seen_q < CW'(WIN)));

  assert_level_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !trig) |=> (!en || $stable(level_o)));
endmodule

bind fastlock_boost_ctrl fastlock_boost_chk #(.LVL_W(LVL_W), .WIN(WIN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .trig    (trig_w),
  .fr_i    (fr_i),
  .code_i  (code_i),
  .level_o (boost_level_o),
  .en      (drive_en_o)
);

// File: tb/fastlock_boost_ctrl_tb.sv
`timescale 1ns/1ps
module fastlock_boost_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] code_i;
  logic       fr_i, opr_i, le_i;
  logic [4:0] boost_level_o;
  logic       drive_en_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model state
  bit       m_en;
  bit [4:0] m_lvl;
  int       m_cnt;
  bit       p_opr, p_le;

  always #2 clk = ~clk;

  fastlock_boost_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .code_i(code_i), .fr_i(fr_i),
    .opr_i(opr_i), .le_i(le_i), .boost_level_o(boost_level_o),
    .drive_en_o(drive_en_o)
  );

  function automatic bit [4:0] exp_level();
    return m_en ? m_lvl : 5'd0;
  endfunction

  task automatic check(string tag);
    n_vec++;
    if (drive_en_o !== m_en || boost_level_o !== exp_level()) begin
      n_fail++;
      $display("FAIL %s: en=%0b level=%0d expected en=%0b level=%0d",
               tag, drive_en_o, boost_level_o, m_en, exp_level());
    end
  endtask

  task automatic model_clock();
    bit trig;
    trig = (opr_i && !p_opr) || (!le_i && p_le);
    if (trig) begin
      m_lvl = code_i;
      m_cnt = 2;
      m_en  = (code_i != 0);
    end else if (m_en && fr_i) begin
      m_cnt--;
      if (m_cnt == 0) m_en = 0;
    end
    p_opr = opr_i;
    p_le  = le_i;
  endtask

  task automatic step(bit o, bit l, bit f, bit [4:0] c, string tag);
    opr_i = o; le_i = l; fr_i = f; code_i = c;
    @(posedge clk);
    model_clock();
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0427));
    rst_n = 1'b0; opr_i = 0; le_i = 0; fr_i = 0; code_i = 5'd0;
    m_en = 0; m_lvl = 0; m_cnt = 0; p_opr = 0; p_le = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release");

    // R2: OPR rise, two strobes close the window
    step(1, 0, 0, 5'd9,  "R2 edge cycle");
    step(1, 0, 0, 5'd3,  "R2 driving, R10 code change ignored");
    step(1, 0, 1, 5'd3,  "R4 first strobe");
    step(1, 0, 0, 5'd3,  "R4 still driving");
    step(1, 0, 1, 5'd3,  "R4 second strobe");
    step(1, 0, 0, 5'd3,  "R8 released");
    // R9: OPR fall and LE rise do nothing
    step(0, 0, 0, 5'd7,  "R9 opr fall");
    step(0, 1, 0, 5'd7,  "R9 le rise");
    // R3: LE fall with a strobe on the same cycle (R5)
    step(0, 0, 1, 5'd21, "R3 R5 le fall with strobe");
    step(0, 0, 1, 5'd0,  "R5 first counted strobe");
    step(0, 1, 0, 5'd0,  "R9 le rise during window");
    // R7: retrigger on the closing strobe
    step(1, 1, 1, 5'd30, "R7 retrigger on second strobe");
    step(1, 1, 1, 5'd30, "R7 one strobe after restart");
    step(1, 1, 0, 5'd30, "R7 window still open");
    step(1, 1, 1, 5'd30, "R7 closes");
    // R6: zero code never opens, and closes an open window
    step(1, 0, 0, 5'd0,  "R6 zero code le fall");
    step(0, 0, 0, 5'd0,  "R6 idle");
    step(1, 0, 0, 5'd31, "R2 max code");
    step(0, 1, 0, 5'd0,  "R9 during window");
    step(0, 0, 0, 5'd0,  "R6 zero code cancels");
    step(0, 0, 1, 5'd0,  "R6 stays released");

    for (int i = 0; i < 4000; i++) begin
      bit o, l, f;
      bit [4:0] c;
      o = (($urandom % 8) == 0) ? ~opr_i : opr_i;
      l = (($urandom % 8) == 0) ? ~le_i  : le_i;
      f = (($urandom % 3) == 0);
      c = (($urandom % 5) == 0) ? 5'd0 : 5'($urandom);
      step(o, l, f, c, "R2 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule